// File: doc/BRIEF.md
# Dual-Port GPIO Expander Register File

This block is the configuration and data store behind a two-port, 8-bit-per-port general purpose I/O expander. A serial front end, not part of this block, first loads a register address and then performs a run of byte reads or writes. The block decodes each byte against one of two address layouts and then moves its internal address pointer on. A bit in the shared configuration register selects the layout. In the interleaved layout the A and B copies of each register sit side by side. In the segregated layout port A and port B each occupy their own block of addresses.

The block holds, for each port, the pin direction, input inversion, change-interrupt enable, compare value, compare-mode select, pull-up enable and output latch registers. The change-flag and capture values come from the interrupt logic and are presented as read-only. The block drives the pad output enables, output levels and qualified pull-up enables directly. It also hands the interrupt settings to the interrupt logic. Reading the port register returns the pin levels after optional per-bit inversion. Writing the port register lands in the output latch.

Top module: `gpx_regfile`

## Requirements
- R1: After reset every direction bit is 1 and every other writable register, the configuration register included, is 00h, so `pin_oe`, `pin_out` and `pull_en` are all zero and the pointer is 00h.
- R2: With layout bit (config bit 7) = 0, address 2k+p selects register k of port p (p=0 is port A) for k = 0..10, in the order direction, inversion, interrupt enable, compare value, compare mode, configuration, pull-up, flag, capture, port, latch. This covers addresses 00h to 15h.
- R3: With layout bit = 1, address 16p+k selects register k of port p in the same order. Addresses 0Bh–0Fh and anything above 1Ah read 00h and ignore writes.
- R4: A write to the port register updates that port's output latch. A read of the port register returns the pin inputs XOR the inversion register. A read of the latch returns the latch.
- R5: The configuration register is one register seen at both of its addresses. Its bits are layout (7), mirror (6), pointer-hold (5), slew-disable (4), hardware-address-enable (3), open-drain (2) and interrupt polarity (1). Bit 0 always reads 0.
- R6: With pointer-hold = 0, each byte access moves the pointer up by one. From the last address (15h with layout 0, 1Ah with layout 1) or above, it wraps to 00h.
- R7: With pointer-hold = 1 and layout 0, each byte access flips pointer bit 0, so it alternates within the A/B pair.
- R8: With pointer-hold = 1 and layout 1, the pointer does not move on byte accesses.
- R9: Writes to the flag and capture registers change nothing. Reads of them return the `flag_in` and `cap_in` values of the addressed port.
- R10: The pointer step after a byte that writes the configuration register follows the old setting. The next access decodes with the new setting.
- R11: `pin_oe` bit i is 1 exactly when direction bit i is 0. `pin_out` equals the latches. `pull_en` bit i is the pull-up bit gated by direction bit i being 1.
- R12: A pointer load takes priority: a read or write strobe in the same cycle is ignored and the pointer takes `addr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_load | input | 1 | Load pointer from addr_in |
| addr_in | input | 8 | Register address to load |
| wr_en | input | 1 | Write one byte at the pointer, then step |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read one byte at the pointer, then step |
| rd_data | output | 8 | Data at the pointer (combinational) |
| ptr_out | output | 8 | Current pointer |
| pin_in | input | 16 | Pad input levels, [7:0] port A, [15:8] port B |
| flag_in | input | 16 | Change flags from the interrupt logic |
| cap_in | input | 16 | Captured pin values from the interrupt logic |
| pin_oe | output | 16 | Pad output enables |
| pin_out | output | 16 | Pad output levels |
| pull_en | output | 16 | Pull-up enables, inputs only |
| irq_en | output | 16 | Change-interrupt enables |
| irq_def | output | 16 | Compare values |
| irq_cmp | output | 16 | Compare-mode selects |
| cfg_out | output | 8 | Configuration register |

## Verification
Directed sequences cover each pointer mode: an increment run up to and past the wrap point in both layouts, an alternating pair, and a held pointer. A byte that flips the layout bit in the middle of a run shows whether the old or the new setting steers the step, and whether the new setting is used for the next decode. Random loads, writes and reads over the full 5-bit address space then mix layout and mode changes with random pin and flag inputs. This exposes any confusion between the two layouts, any write leaking into a read-only or unmapped slot, and any missing inversion on port reads.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 8;
  localparam int NUM_REGS    = 11;
  localparam int BANK_STRIDE = 16;

  typedef enum logic [3:0] {
    RG_DIR  = 4'd0,
    RG_POL  = 4'd1,
    RG_IEN  = 4'd2,
    RG_DEF  = 4'd3,
    RG_ICTL = 4'd4,
    RG_CFG  = 4'd5,
    RG_PU   = 4'd6,
    RG_FLAG = 4'd7,
    RG_CAP  = 4'd8,
    RG_PORT = 4'd9,
    RG_LAT  = 4'd10
  } reg_idx_e;

  typedef struct packed {
    logic     valid;
    logic     port;
    reg_idx_e idx;
  } dec_t;

  typedef struct packed {
    logic bank;
    logic mirror;
    logic seq_dis;
    logic slew_dis;
    logic haddr_en;
    logic odrain;
    logic int_pol;
    logic rsvd;
  } cfg_t;

  // Highest mapped address for a given layout.
  function automatic logic [ADDR_W-1:0] last_addr(input logic bank);
    if (bank) return ADDR_W'(BANK_STRIDE + NUM_REGS - 1);
    return ADDR_W'(2 * NUM_REGS - 1);
  endfunction

  // Address to (valid, port, register) under the selected layout.
  function automatic dec_t map_addr(input logic bank, input logic [ADDR_W-1:0] a);
    dec_t d;
    d.valid = 1'b0;
    d.port  = 1'b0;
    d.idx   = RG_DIR;
    if (!bank) begin
      if (a < ADDR_W'(2 * NUM_REGS)) begin
        d.valid = 1'b1;
        d.port  = a[0];
        d.idx   = reg_idx_e'(a[4:1]);
      end
    end else begin
      if (a[ADDR_W-1:5] == '0 && a[3:0] < 4'(NUM_REGS)) begin
        d.valid = 1'b1;
        d.port  = a[4];
        d.idx   = reg_idx_e'(a[3:0]);
      end
    end
    return d;
  endfunction

  // Pointer after one byte access.
  function automatic logic [ADDR_W-1:0] next_ptr(input logic bank, input logic seq_dis,
                                                 input logic [ADDR_W-1:0] p);
    if (!seq_dis) return (p >= last_addr(bank)) ? '0 : p + 1'b1;
    if (!bank) return p ^ ADDR_W'(1);
    return p;
  endfunction
endpackage

// File: rtl/gpx_addr_ptr.sv
module gpx_addr_ptr
  import gpx_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic          bank,
  input  logic          seq_dis,
  output logic [AW-1:0] ptr
);
  logic          step_eff;
  logic [AW-1:0] ptr_adv;

  assign step_eff = step && !load;
  assign ptr_adv  = AW'(next_ptr(bank, seq_dis, ADDR_W'(ptr)));

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr <= '0;
    else if (load)     ptr <= load_addr;
    else if (step_eff) ptr <= ptr_adv;
  end

  p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr == $past(load_addr));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_eff && !seq_dis && ptr >= AW'(last_addr(bank))) |=> ptr == '0);
  p_incr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_eff && !seq_dis && ptr < AW'(last_addr(bank))) |=> ptr == $past(ptr) + 1'b1);
  p_pair_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_eff && seq_dis && !bank) |=> ptr[0] != $past(ptr[0]) && ptr[AW-1:1] == $past(ptr[AW-1:1]));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_eff && seq_dis && bank) |=> $stable(ptr));
endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
  import gpx_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  reg_idx_e     wr_idx,
  input  logic [W-1:0] wr_data,
  input  reg_idx_e     rd_idx,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] flag_in,
  input  logic [W-1:0] cap_in,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] dir,
  output logic [W-1:0] pol,
  output logic [W-1:0] ien,
  output logic [W-1:0] defv,
  output logic [W-1:0] ictl,
  output logic [W-1:0] pu,
  output logic [W-1:0] lat
);
  logic [W-1:0] pin_view;
  logic         lat_hit;

  assign pin_view = pin_in ^ pol;
  assign lat_hit  = wr_stb && (wr_idx == RG_PORT || wr_idx == RG_LAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir  <= '1;
      pol  <= '0;
      ien  <= '0;
      defv <= '0;
      ictl <= '0;
      pu   <= '0;
      lat  <= '0;
    end else if (wr_stb) begin
      case (wr_idx)
        RG_DIR:          dir  <= wr_data;
        RG_POL:          pol  <= wr_data;
        RG_IEN:          ien  <= wr_data;
        RG_DEF:          defv <= wr_data;
        RG_ICTL:         ictl <= wr_data;
        RG_PU:           pu   <= wr_data;
        RG_PORT, RG_LAT: lat  <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      RG_DIR:  rd_data = dir;
      RG_POL:  rd_data = pol;
      RG_IEN:  rd_data = ien;
      RG_DEF:  rd_data = defv;
      RG_ICTL: rd_data = ictl;
      RG_PU:   rd_data = pu;
      RG_FLAG: rd_data = flag_in;
      RG_CAP:  rd_data = cap_in;
      RG_PORT: rd_data = pin_view;
      RG_LAT:  rd_data = lat;
      default: rd_data = '0;
    endcase
  end

  p_port_to_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx == RG_PORT) |=> lat == $past(wr_data));
  p_latch_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_hit |=> $stable(lat));
  p_readonly_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_idx == RG_FLAG || wr_idx == RG_CAP))
      |=> $stable({dir, pol, ien, defv, ictl, pu, lat}));
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int PORT_W = DATA_W,
  parameter int AW     = ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ptr_load,
  input  logic [AW-1:0]       addr_in,
  input  logic                wr_en,
  input  logic [PORT_W-1:0]   wr_data,
  input  logic                rd_en,
  output logic [PORT_W-1:0]   rd_data,
  output logic [AW-1:0]       ptr_out,
  input  logic [2*PORT_W-1:0] pin_in,
  input  logic [2*PORT_W-1:0] flag_in,
  input  logic [2*PORT_W-1:0] cap_in,
  output logic [2*PORT_W-1:0] pin_oe,
  output logic [2*PORT_W-1:0] pin_out,
  output logic [2*PORT_W-1:0] pull_en,
  output logic [2*PORT_W-1:0] irq_en,
  output logic [2*PORT_W-1:0] irq_def,
  output logic [2*PORT_W-1:0] irq_cmp,
  output logic [7:0]          cfg_out
);
  localparam int NPORT = 2;
  localparam int PW    = 2 * PORT_W;

  cfg_t              cfg_q;
  dec_t              dec;
  logic              acc_wr;
  logic              acc_rd;
  logic              cfg_wr;
  logic [NPORT-1:0]  port_wr;
  logic [PORT_W-1:0] port_rd [NPORT];
  logic [PW-1:0]     dir_v;
  logic [PW-1:0]     pol_v;
  logic [PW-1:0]     pu_v;

  assign acc_wr = wr_en && !ptr_load;
  assign acc_rd = rd_en && !ptr_load;
  assign dec    = map_addr(cfg_q.bank, ADDR_W'(ptr_out));
  assign cfg_wr = acc_wr && dec.valid && dec.idx == RG_CFG;

  gpx_addr_ptr #(.AW(AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ptr_load),
    .load_addr (addr_in),
    .step      (wr_en || rd_en),
    .bank      (cfg_q.bank),
    .seq_dis   (cfg_q.seq_dis),
    .ptr       (ptr_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_t'({wr_data[7:1], 1'b0});
  end

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
    assign port_wr[gp] = acc_wr && dec.valid && dec.port == gp[0] && dec.idx != RG_CFG;

    gpx_port_regs #(.W(PORT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (port_wr[gp]),
      .wr_idx  (dec.idx),
      .wr_data (wr_data),
      .rd_idx  (dec.idx),
      .pin_in  (pin_in [gp*PORT_W +: PORT_W]),
      .flag_in (flag_in[gp*PORT_W +: PORT_W]),
      .cap_in  (cap_in [gp*PORT_W +: PORT_W]),
      .rd_data (port_rd[gp]),
      .dir     (dir_v  [gp*PORT_W +: PORT_W]),
      .pol     (pol_v  [gp*PORT_W +: PORT_W]),
      .ien     (irq_en [gp*PORT_W +: PORT_W]),
      .defv    (irq_def[gp*PORT_W +: PORT_W]),
      .ictl    (irq_cmp[gp*PORT_W +: PORT_W]),
      .pu      (pu_v   [gp*PORT_W +: PORT_W]),
      .lat     (pin_out[gp*PORT_W +: PORT_W])
    );
  end

  assign pin_oe  = ~dir_v;
  assign pull_en = pu_v & dir_v;
  assign cfg_out = cfg_q;

  always_comb begin
    if (!dec.valid)              rd_data = '0;
    else if (dec.idx == RG_CFG)  rd_data = PORT_W'(cfg_q);
    else                         rd_data = port_rd[dec.port];
  end

  p_unmapped_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !dec.valid) |=> $stable(cfg_q) && $stable(pin_out) && $stable(pin_oe));
  p_cfg_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr) |-> cfg_out[0] == 1'b0);
  p_pull_only_inputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & pin_oe) == '0);
  p_load_blocks_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load && wr_en) |=> $stable(cfg_q) && $stable(pin_out) && $stable(pin_oe));
  p_unused_pol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && dec.valid && dec.idx == RG_PORT && !dec.port)
      |-> rd_data == (pin_in[PORT_W-1:0] ^ pol_v[PORT_W-1:0]));
endmodule

// File: tb/gpx_regfile_tb.sv
module gpx_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ptr_load, wr_en, rd_en;
  logic [7:0]  addr_in, wr_data, rd_data, ptr_out, cfg_out;
  logic [15:0] pin_in, flag_in, cap_in;
  logic [15:0] pin_oe, pin_out, pull_en, irq_en, irq_def, irq_cmp;

  int n_run  = 0;
  int n_fail = 0;

  logic [7:0] m_reg [2][11];
  logic [7:0] m_cfg;
  logic [7:0] m_ptr;

  always #4 clk = ~clk;

  gpx_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .addr_in(addr_in),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ptr_out(ptr_out), .pin_in(pin_in), .flag_in(flag_in), .cap_in(cap_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en), .irq_en(irq_en),
    .irq_def(irq_def), .irq_cmp(irq_cmp), .cfg_out(cfg_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Bench view of the two address layouts.
  function automatic bit tb_map(input logic bank, input logic [7:0] a,
                                output int idx, output int prt);
    int hi, lo;
    idx = 0; prt = 0;
    if (bank == 1'b0) begin
      if (a > 8'h15) return 1'b0;
      idx = int'(a) / 2; prt = int'(a) % 2;
      return 1'b1;
    end
    hi = int'(a) / 16; lo = int'(a) % 16;
    if (hi > 1 || lo > 10) return 1'b0;
    idx = lo; prt = hi;
    return 1'b1;
  endfunction

  function automatic logic [7:0] tb_adv(input logic [7:0] p, input logic [7:0] c);
    logic [7:0] top;
    top = c[7] ? 8'h1A : 8'h15;
    if (c[5] == 1'b0) return (p < top) ? p + 8'd1 : 8'h00;
    if (c[7] == 1'b0) return {p[7:1], ~p[0]};
    return p;
  endfunction

  function automatic logic [7:0] tb_expect();
    int idx, prt;
    if (!tb_map(m_cfg[7], m_ptr, idx, prt)) return 8'h00;
    case (idx)
      5: return m_cfg;
      7: return flag_in[prt*8 +: 8];
      8: return cap_in[prt*8 +: 8];
      9: return pin_in[prt*8 +: 8] ^ m_reg[prt][1];
      default: return m_reg[prt][idx];
    endcase
  endfunction

  task automatic check_pins(input string tag);
    chk({tag, " oe"},   pin_oe,  {~m_reg[1][0], ~m_reg[0][0]});
    chk({tag, " out"},  pin_out, {m_reg[1][10], m_reg[0][10]});
    chk({tag, " pull"}, pull_en, {m_reg[1][6] & m_reg[1][0], m_reg[0][6] & m_reg[0][0]});
  endtask

  task automatic do_load(input logic [7:0] a);
    @(negedge clk);
    ptr_load = 1'b1; addr_in = a;
    @(posedge clk); #1;
    ptr_load = 1'b0;
    m_ptr = a;
  endtask

  task automatic do_wr(input logic [7:0] d);
    int idx, prt;
    logic [7:0] oc;
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    oc = m_cfg;
    if (tb_map(m_cfg[7], m_ptr, idx, prt)) begin
      if (idx == 5) m_cfg = d & 8'hFE;
      else if (idx == 9) m_reg[prt][10] = d;
      else if (idx != 7 && idx != 8) m_reg[prt][idx] = d;
    end
    m_ptr = tb_adv(m_ptr, oc);
  endtask

  task automatic do_rd(input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    #1 chk(tag, rd_data, tb_expect());
    @(posedge clk); #1;
    rd_en = 1'b0;
    m_ptr = tb_adv(m_ptr, m_cfg);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; ptr_load = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr_in = '0; wr_data = '0;
    pin_in = 16'hC35A; flag_in = 16'h81_24; cap_in = 16'h7E_0F;
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 11; k++) m_reg[p][k] = (k == 0) ? 8'hFF : 8'h00;
    m_cfg = 8'h00; m_ptr = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 ptr", ptr_out, 8'h00);
    chk("R1 oe", pin_oe, 16'h0000);
    chk("R1 pull", pull_en, 16'h0000);
    chk("R1 cfg", cfg_out, 8'h00);
    do_rd("R1 dirA");
    do_rd("R1 dirB");
    do_rd("R1 polA");

    // R2 / R11: interleaved direction and pull-ups
    do_load(8'h00);
    do_wr(8'h0F);
    do_wr(8'hF0);
    chk("R6 ptr after two writes", ptr_out, 8'h02);
    chk("R11 oe", pin_oe, 16'h0FF0);
    do_load(8'h0C);
    do_wr(8'hFF);
    do_wr(8'h3C);
    chk("R11 pull", pull_en, 16'h300F);
    check_pins("R11");

    // R4: latch, port write, inverted port read
    do_load(8'h14);
    do_wr(8'hA5);
    do_wr(8'h3C);
    chk("R11 out", pin_out, 16'h3CA5);
    do_load(8'h12);
    do_wr(8'h11);
    chk("R4 port write to latch", pin_out, 16'h3C11);
    do_load(8'h14);
    do_rd("R4 latch read");
    do_load(8'h02);
    do_wr(8'hFF);
    do_load(8'h12);
    @(negedge clk);
    #1 chk("R4 inverted read", rd_data, 8'hA5);
    do_rd("R4 port A");
    do_rd("R4 port B");

    // R12: load beats a same-cycle write
    @(negedge clk);
    ptr_load = 1'b1; addr_in = 8'h00; wr_en = 1'b1; wr_data = 8'h00;
    @(posedge clk); #1;
    ptr_load = 1'b0; wr_en = 1'b0; m_ptr = 8'h00;
    chk("R12 ptr", ptr_out, 8'h00);
    chk("R12 write dropped", pin_oe, 16'h0FF0);

    // R9: flag and capture are read-only
    do_load(8'h0E);
    do_wr(8'hFF);
    do_wr(8'hFF);
    do_load(8'h10);
    do_wr(8'h00);
    do_wr(8'h00);
    check_pins("R9");
    do_load(8'h0E);
    do_rd("R9 flagA");
    do_rd("R9 flagB");
    do_rd("R9 capA");
    do_rd("R9 capB");

    // R6: wrap at 15h in interleaved layout
    do_load(8'h15);
    do_rd("R6 last");
    chk("R6 wrap 15h", ptr_out, 8'h00);

    // R5 / R7: config write, bit 0 dropped, pair toggle
    do_load(8'h0A);
    do_wr(8'h23);
    chk("R10 step uses old mode", ptr_out, 8'h0B);
    chk("R5 cfg", cfg_out, 8'h22);
    do_rd("R5 cfg alias");
    chk("R7 toggle", ptr_out, 8'h0A);
    do_load(8'h12);
    do_rd("R7 pA");
    chk("R7 to B", ptr_out, 8'h13);
    do_rd("R7 pB");
    chk("R7 back to A", ptr_out, 8'h12);

    // R10 / R3 / R8: switch to segregated layout mid-run
    do_load(8'h0A);
    do_wr(8'hA0);
    chk("R10 ptr", ptr_out, 8'h0B);
    @(negedge clk);
    #1 chk("R3 unmapped 0Bh", rd_data, 8'h00);
    do_rd("R10 new layout");
    chk("R8 hold", ptr_out, 8'h0B);
    do_wr(8'h55);
    check_pins("R3 unmapped write");
    chk("R3 cfg kept", cfg_out, 8'hA0);
    do_load(8'h05);
    do_rd("R5 cfg A side");
    do_load(8'h15);
    do_rd("R5 cfg B side");
    do_load(8'h10);
    do_rd("R3 dirB");
    do_load(8'h1C);
    do_rd("R3 above map");

    // R6: wrap at 1Ah in segregated layout
    do_load(8'h05);
    do_wr(8'h80);
    chk("R8 hold on cfg write", ptr_out, 8'h05);
    do_load(8'h1A);
    do_rd("R6 latB");
    chk("R6 wrap 1Ah", ptr_out, 8'h00);

    // Random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 2) do_load(8'($urandom % 32));
      else if (op < 5) do_wr(8'($urandom));
      else if (op < 9) do_rd(m_cfg[7] ? "R3 random read" : "R2 random read");
      else begin
        @(negedge clk);
        pin_in = 16'($urandom); flag_in = 16'($urandom); cap_in = 16'($urandom);
      end
      @(negedge clk);
      chk("R6 ptr model", ptr_out, m_ptr);
      chk("R5 cfg model", cfg_out, m_cfg);
      check_pins("R11 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule